// File: doc/BRIEF.md
# In-Order Completion Reorder Buffer

This block puts results back into the order in which their operations began, even when the operations finish in a different order. Before a producer starts an operation, it takes a ticket from the block. When the operation finishes, it writes its result back under that ticket. The consumer receives results strictly in ticket order. A result that arrives early waits in its slot until every older ticket has been written and read.

Storage is a ring of 2^TOK_W slots, 16 by default. Each slot holds a data word and a valid flag. An issue pointer, a release pointer and an occupancy counter manage the ring. Ticket requests and result reads are valid/ready streams. A ticket request completes on a cycle where `tok_req_valid` and `tok_req_ready` are both high. A read completes on a cycle where `rd_valid` and `rd_ready` are both high. The block drops `tok_req_ready` while the ring is fully booked, and the producer must hold its request until ready returns. The consumer may hold `rd_ready` low for as long as it likes, and the block keeps `rd_data` steady while it waits. The write-back port has no back-pressure and is always accepted.

Top module: `ordbuf_top`

## Requirements
- R1: After reset, `tok_req_ready` is 1, `rd_valid` is 0 and `tok_id` is 0.
- R2: `tok_id` shows the ticket that the next request will receive. Each completed request advances it by one, and it wraps from 2^TOK_W-1 back to 0.
- R3: A ticket is outstanding from the request that issues it until the read that releases it. When 2^TOK_W tickets are outstanding, `tok_req_ready` is 0.
- R4: A write with `wr_en` high stores `wr_data` into the slot named by `wr_tok` and marks that slot valid from the next cycle on.
- R5: `rd_valid` is 1 only when at least one ticket is outstanding and the slot of the oldest outstanding ticket is valid. Results written for younger tickets stay hidden until then.
- R6: A completed read returns the oldest ticket's data on `rd_data` and makes the next ticket the oldest. Results therefore leave in issue order.
- R7: Issuing a ticket marks its slot invalid. Data left in that slot from an earlier use of the same ticket number is never presented.
- R8: A ticket request, a write-back and a read can all complete in the same cycle, and all three take effect.
- R9: A write to the oldest slot in the same cycle as `rd_ready` does not raise `rd_valid` in that cycle. It raises `rd_valid` in the next cycle.
- R10: A write to a ticket that is not outstanding is illegal, and an assertion reports it.
- R11: A ticket request while `tok_req_ready` is 0, or `rd_ready` while `rd_valid` is 0, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_req_valid | input | 1 | Producer requests a ticket |
| tok_req_ready | output | 1 | A ticket can be issued this cycle |
| tok_id | output | TOK_W | Ticket that the next request receives |
| wr_en | input | 1 | Result write-back strobe |
| wr_tok | input | TOK_W | Ticket of the result being written |
| wr_data | input | DATA_W | Result data |
| rd_valid | output | 1 | The oldest result is ready |
| rd_ready | input | 1 | Consumer accepts the oldest result |
| rd_data | output | DATA_W | Data of the oldest result |

## Verification
Two functions can fall in the same cycle in a way that matters here.

The first is a write-back that lands on the oldest slot while the consumer is already asserting `rd_ready`. The bench drives that write with `rd_ready` high. It confirms that `rd_valid` stays low in the write cycle, and that the result is presented and accepted exactly once in the following cycle.

The second is a single cycle that carries a ticket request, a write-back to a younger ticket and a read of the oldest result together. The bench checks three effects from that one edge: the scoreboard pops the oldest result, the new ticket number advances, and the younger result becomes the next one presented with its own data.

// File: rtl/ordbuf_pkg.sv
package ordbuf_pkg;
  // Default ticket width: 2^TOK_W slots in the ring.
  localparam int unsigned ORDBUF_TOK_W_DEF  = 4;
  // Default result width.
  localparam int unsigned ORDBUF_DATA_W_DEF = 32;
endpackage

// File: rtl/ordbuf_ptrs.sv
module ordbuf_ptrs #(
  parameter int unsigned TOK_W = ordbuf_pkg::ORDBUF_TOK_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic             release_en,
  output logic [TOK_W-1:0] in_idx,
  output logic [TOK_W-1:0] out_idx,
  output logic [TOK_W:0]   count,
  output logic             not_full,
  output logic             not_empty
);
  localparam int unsigned DEPTH = 1 << TOK_W;
  localparam logic [TOK_W:0] DEPTH_C = TOK_W'(0) | (TOK_W+1)'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_idx  <= '0;
      out_idx <= '0;
      count   <= '0;
    end else begin
      if (issue_en)   in_idx  <= in_idx + 1'b1;
      if (release_en) out_idx <= out_idx + 1'b1;
      case ({issue_en, release_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign not_full  = (count != DEPTH_C);
  assign not_empty = (count != '0);

  // R3: the ring never holds more than DEPTH tickets
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  // R2: each issue advances the next ticket by one, modulo DEPTH
  p_issue_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |=> in_idx == $past(in_idx) + 1'b1);

  // R6: each release advances the oldest ticket by one
  p_release_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_en |=> out_idx == $past(out_idx) + 1'b1);

  // R11: with no issue and no release, the pointers and the count hold
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_en && !release_en) |=> ($stable(in_idx) && $stable(out_idx) && $stable(count)));
endmodule

// File: rtl/ordbuf_slots.sv
module ordbuf_slots #(
  parameter int unsigned TOK_W  = ordbuf_pkg::ORDBUF_TOK_W_DEF,
  parameter int unsigned DATA_W = ordbuf_pkg::ORDBUF_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [TOK_W-1:0]  clr_idx,
  input  logic              wr_en,
  input  logic [TOK_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TOK_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << TOK_W;

  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  clr_hit;
  logic [DEPTH-1:0]  wr_hit;

  // One-hot decode of the clear and write targets, one pair per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign clr_hit[g] = clr_en && (clr_idx == TOK_W'(g));
    assign wr_hit[g]  = wr_en  && (wr_idx  == TOK_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (clr_hit[s])     vld_q[s] <= 1'b0;
        else if (wr_hit[s]) vld_q[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (wr_hit[s]) data_q[s] <= wr_data;
    end
  end

  // The read port sees only registered state, as it stood before this cycle.
  assign rd_vld  = vld_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  // R4: a written slot reads back valid with the written data
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(clr_en && clr_idx == wr_idx)) |=>
      (vld_q[$past(wr_idx)] && data_q[$past(wr_idx)] == $past(wr_data)));

  // R7: an issued slot starts empty
  p_issue_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !vld_q[$past(clr_idx)]);
endmodule

// File: rtl/ordbuf_top.sv
module ordbuf_top #(
  parameter int unsigned TOK_W  = ordbuf_pkg::ORDBUF_TOK_W_DEF,
  parameter int unsigned DATA_W = ordbuf_pkg::ORDBUF_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_req_valid,
  output logic              tok_req_ready,
  output logic [TOK_W-1:0]  tok_id,
  input  logic              wr_en,
  input  logic [TOK_W-1:0]  wr_tok,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << TOK_W;

  logic             issue_en;
  logic             release_en;
  logic [TOK_W-1:0] in_idx;
  logic [TOK_W-1:0] out_idx;
  logic [TOK_W:0]   count;
  logic             not_full;
  logic             not_empty;
  logic             head_vld;
  logic [TOK_W-1:0] wr_age;

  assign issue_en      = tok_req_valid && not_full;
  assign release_en    = rd_valid && rd_ready;
  assign tok_req_ready = not_full;
  assign tok_id        = in_idx;
  assign rd_valid      = not_empty && head_vld;

  ordbuf_ptrs #(.TOK_W(TOK_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_en   (issue_en),
    .release_en (release_en),
    .in_idx     (in_idx),
    .out_idx    (out_idx),
    .count      (count),
    .not_full   (not_full),
    .not_empty  (not_empty)
  );

  ordbuf_slots #(.TOK_W(TOK_W), .DATA_W(DATA_W)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (issue_en),
    .clr_idx (in_idx),
    .wr_en   (wr_en),
    .wr_idx  (wr_tok),
    .wr_data (wr_data),
    .rd_idx  (out_idx),
    .rd_vld  (head_vld),
    .rd_data (rd_data)
  );

  // Age of the written ticket relative to the oldest outstanding one.
  assign wr_age = wr_tok - out_idx;

  // R10: a write-back must name an outstanding ticket
  p_legal_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_age} < count));

  // R3: no ticket is offered when the ring is fully booked
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == (TOK_W+1)'(DEPTH)) |-> !tok_req_ready);

  // R5: nothing is presented while no ticket is outstanding
  p_valid_needs_ticket_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (count != '0));

  // R6: a stalled result keeps its data until it is taken
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !wr_en) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/ordbuf_top_bench.sv
module ordbuf_top_bench;
  localparam int TOK_W  = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tok_req_valid;
  logic              tok_req_ready;
  logic [TOK_W-1:0]  tok_id;
  logic              wr_en;
  logic [TOK_W-1:0]  wr_tok;
  logic [DATA_W-1:0] wr_data;
  logic              rd_valid;
  logic              rd_ready;
  logic [DATA_W-1:0] rd_data;

  int tests  = 0;
  int fails  = 0;
  int reads  = 0;
  int issued = 0;
  int cycles = 0;
  logic [DATA_W-1:0] exp_q [$];
  logic [DATA_W-1:0] dat_of_tok [16];

  always #4 clk = ~clk;

  ordbuf_top #(.TOK_W(TOK_W), .DATA_W(DATA_W)) u_ordbuf_top (
    .clk(clk), .rst_n(rst_n),
    .tok_req_valid(tok_req_valid), .tok_req_ready(tok_req_ready), .tok_id(tok_id),
    .wr_en(wr_en), .wr_tok(wr_tok), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard on every completed read (R6 ordering).
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      reads++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected result", rd_data, 0);
      end else begin
        check(rd_data == exp_q[0], "R6 order", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(output logic [TOK_W-1:0] t);
    logic [DATA_W-1:0] d;
    tok_req_valid = 1'b1;
    t = tok_id;
    check(tok_req_ready, "R3 ready while not full", tok_req_ready, 1);
    d = 32'hC0DE_0000 ^ (32'(issued) * 32'h1357);
    dat_of_tok[t] = d;
    exp_q.push_back(d);
    issued++;
    @(posedge clk); #1;
    tok_req_valid = 1'b0;
  endtask

  task automatic write(input logic [TOK_W-1:0] t);
    wr_en = 1'b1; wr_tok = t; wr_data = dat_of_tok[t];
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    logic [TOK_W-1:0] t;
    logic [TOK_W-1:0] tk [16];
    logic [TOK_W-1:0] ta, tb2, tc;
    rst_n = 1'b0; tok_req_valid = 1'b0; wr_en = 1'b0; wr_tok = '0; wr_data = '0; rd_ready = 1'b0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    check(tok_req_ready == 1'b1, "R1 ready", tok_req_ready, 1);
    check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    check(tok_id == '0, "R1 tok_id", tok_id, 0);

    // R2/R5: four tickets, written out of order, released in order
    rd_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      issue(t);
      check(t == TOK_W'(i), "R2 ticket number", t, i);
    end
    write(2); check(!rd_valid, "R5 younger hidden", rd_valid, 0);
    write(3); check(!rd_valid, "R5 younger hidden", rd_valid, 0);
    write(1); check(!rd_valid, "R5 younger hidden", rd_valid, 0);
    write(0);
    idle(6);
    check(reads == 4, "R6 four released", reads, 4);

    // R3/R2: fill the ring, tickets wrap
    rd_ready = 1'b0;
    for (int i = 0; i < 16; i++) begin
      issue(tk[i]);
      check(tk[i] == TOK_W'(i + 4), "R2 wrap", tk[i], (i + 4) % 16);
    end
    check(tok_req_ready == 1'b0, "R3 full blocks", tok_req_ready, 0);
    // R11: request while not ready is ignored
    tok_req_valid = 1'b1; idle(1); tok_req_valid = 1'b0;
    check(tok_id == 4'd4, "R11 ignored request", tok_id, 4);
    check(tok_req_ready == 1'b0, "R11 still full", tok_req_ready, 0);
    // R11: rd_ready without rd_valid pops nothing
    rd_ready = 1'b1; idle(2); rd_ready = 1'b0;
    check(reads == 4, "R11 no spurious read", reads, 4);
    for (int i = 15; i >= 1; i--) begin
      write(tk[i]);
      check(!rd_valid, "R5 oldest missing", rd_valid, 0);
    end
    write(tk[0]);
    check(rd_valid, "R4 oldest written", rd_valid, 1);
    check(rd_data == dat_of_tok[tk[0]], "R4 data stored", rd_data, dat_of_tok[tk[0]]);
    rd_ready = 1'b1;
    idle(20);
    check(reads == 20, "R6 full drain", reads, 20);

    // R7: reissued slot 4 held stale valid data
    issue(t);
    check(t == 4'd4, "R7 ticket reuse", t, 4);
    check(!rd_valid, "R7 stale data hidden", rd_valid, 0);
    write(t);
    idle(2);
    check(reads == 21, "R7 fresh result read", reads, 21);

    // R9: write to oldest slot while rd_ready is high
    issue(t);
    wr_en = 1'b1; wr_tok = t; wr_data = dat_of_tok[t];
    @(negedge clk);
    check(!rd_valid, "R9 same-cycle write not visible", rd_valid, 0);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check(rd_valid, "R9 visible next cycle", rd_valid, 1);
    idle(2);
    check(reads == 22, "R9 read once", reads, 22);

    // R8: issue, write and read in one cycle
    rd_ready = 1'b0;
    issue(ta); issue(tb2);
    write(ta);
    tok_req_valid = 1'b1; tc = tok_id; dat_of_tok[tc] = 32'h5A5A_0000 + 32'(issued);
    exp_q.push_back(dat_of_tok[tc]); issued++;
    wr_en = 1'b1; wr_tok = tb2; wr_data = dat_of_tok[tb2];
    rd_ready = 1'b1;
    @(posedge clk); #1;
    tok_req_valid = 1'b0; wr_en = 1'b0; rd_ready = 1'b0;
    check(reads == 23, "R8 read took effect", reads, 23);
    check(tok_id == tc + 1'b1, "R8 issue took effect", tok_id, tc + 1'b1);
    check(rd_valid && rd_data == dat_of_tok[tb2], "R8 write took effect", rd_data, dat_of_tok[tb2]);
    rd_ready = 1'b1;
    write(tc);
    idle(4);
    check(reads == 25, "R8 drained", reads, 25);
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule